// File: doc/BRIEF.md
# Root-Raised-Cosine Pulse-Shaping Interpolator

This block turns a stream of symbol-rate I and Q impulses into pulse-shaped samples at eight times the symbol rate. Each channel is a real FIR filter with a root-raised-cosine response, roll-off 0.5, spanning eight symbol periods (four on each side of the centre). The I and Q channels are filtered separately by identical filters. The filter works as a polyphase interpolator. Each channel keeps only the last eight symbol values. After every symbol it produces eight samples, one per clock, each from one polyphase branch of eight taps. The 64 taps are never run at the output rate.

A phase encoder upstream presents a signed I/Q pair with a one-cycle strobe, at most once every eight clocks during steady operation. Downstream logic receives a sample strobe with signed 10-bit I/Q values. A burst-start pulse empties the symbol history, so every burst ramps up from silence. The coefficients are computed at elaboration from the pulse formula and scaled by 1024.

Top module: `rrc_interp`

## Requirements
- R1: After reset, smp_vld is 0, smp_i and smp_q are 0, and every symbol-history entry of both channels is 0.
- R2: When sym_vld is captured at a clock edge E, smp_vld is 1 after edges E+1 through E+8 and carries branches 0 to 7 in that order. After that it drops to 0, unless R7 or R8 cuts the sequence short.
- R3: Let x0 be the newest captured symbol value of a channel (signed 10-bit two's complement) and xj the value j symbols older, for j from 0 to 7. The value before scaling of branch p is acc = sum of xj*c[8j+p]. Here c[k] = h((k-32)/8)*1024, rounded half away from zero, and h is the root-raised-cosine pulse with roll-off 0.5 and unit symbol period.
- R4: The I and Q channels keep separate histories, use the same coefficients, and do not affect each other.
- R5: A sample is floor((acc+512)/1024): divide by 1024 and round half toward plus infinity.
- R6: The scaled result is saturated to the signed 10-bit range from -512 to 511.
- R7: When burst_start is captured, every history entry is zeroed. If sym_vld is captured at the same edge, the new symbol becomes the only non-zero entry. A burst_start alone ends any running sample sequence once the sample due at that edge has gone out.
- R8: A strobe captured while a sequence is running still lets the sample due at that edge go out, computed from the older history. The next edge then starts branch 0 of the new symbol.
- R9: While smp_vld is 0, smp_i and smp_q keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| burst_start | input | 1 | Clears both symbol histories |
| sym_vld | input | 1 | One-cycle symbol strobe |
| sym_i | input | IN_W | Signed in-phase impulse value |
| sym_q | input | IN_W | Signed quadrature impulse value |
| smp_vld | output | 1 | Output sample strobe |
| smp_i | output | OUT_W | Signed shaped in-phase sample |
| smp_q | output | OUT_W | Signed shaped quadrature sample |

## Verification
A strobe captured at edge E shows its branch p sample after edge E+1+p. The sample due at the edge that captures a later strobe or a burst start still comes from the old history. The bench drives inputs and samples outputs on falling edges. On the first falling edge after a new strobe it checks the leftover sample computed for the previous symbol, and after that the eight new branches in order. At every other falling edge it checks that smp_vld is 0 and the outputs hold their values. It gets the coefficients from the pulse formula with the standard real math functions, and keeps its own copy of the symbol history to compute each expected sample.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

    localparam int  OSR      = 8;
    localparam int  SPAN     = 8;
    localparam int  NTAP     = OSR * SPAN;
    localparam int  PH_W     = $clog2(OSR);
    localparam int  NUM_CH   = 2;
    localparam real ROLLOFF  = 0.5;
    localparam real PI_R     = 3.14159265358979323846;
    localparam real SQRT2_R  = 1.41421356237309504880;

    typedef logic [PH_W-1:0] phase_t;

    typedef struct packed {
        logic   run;
        phase_t phase;
    } seq_state_t;

    typedef enum int {
        CH_I = 0,
        CH_Q = 1
    } chan_e;

    function automatic real abs_r(input real x);
        return (x < 0.0) ? -x : x;
    endfunction

    // sine by range reduction and a Taylor series, usable at elaboration
    function automatic real sin_r(input real x);
        real a;
        real term;
        real sum;
        a = x;
        while (a > PI_R)  a = a - 2.0 * PI_R;
        while (a < -PI_R) a = a + 2.0 * PI_R;
        term = a;
        sum  = a;
        for (int n = 1; n < 16; n++) begin
            term = -term * a * a / ((2.0 * n) * (2.0 * n + 1.0));
            sum  = sum + term;
        end
        return sum;
    endfunction

    function automatic real cos_r(input real x);
        return sin_r(x + PI_R / 2.0);
    endfunction

    // root-raised-cosine pulse, unit symbol period
    function automatic real rrc_pulse(input real t, input real b);
        real den;
        if (abs_r(t) < 1.0e-12)
            return 1.0 - b + 4.0 * b / PI_R;
        if (abs_r(abs_r(4.0 * b * t) - 1.0) < 1.0e-9)
            return (b / SQRT2_R) * ((1.0 + 2.0 / PI_R) * sin_r(PI_R / (4.0 * b))
                                  + (1.0 - 2.0 / PI_R) * cos_r(PI_R / (4.0 * b)));
        den = PI_R * t * (1.0 - (4.0 * b * t) * (4.0 * b * t));
        return (sin_r(PI_R * t * (1.0 - b)) + 4.0 * b * t * cos_r(PI_R * t * (1.0 + b))) / den;
    endfunction

    // integer tap k of NTAP, centre at NTAP/2, scaled by 2**frac
    function automatic int rrc_coef(input int k, input int frac);
        real t;
        real v;
        t = real'(k - NTAP / 2) / real'(OSR);
        v = rrc_pulse(t, ROLLOFF) * real'(1 << frac);
        if (v >= 0.0)
            return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

endpackage

// File: rtl/rrc_seq_ctrl.sv
module rrc_seq_ctrl
    import rrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       burst_start,
    input  logic       sym_vld,
    output seq_state_t state,
    output logic       out_vld
);

    localparam phase_t LAST = phase_t'(OSR - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= state.run;
            if (sym_vld) begin
                state <= '{run: 1'b1, phase: '0};
            end else if (burst_start || (state.run && state.phase == LAST)) begin
                state <= '0;
            end else if (state.run) begin
                state.phase <= state.phase + phase_t'(1);
            end
        end
    end

    // R1: reset leaves the sequencer idle with no sample strobe
    p_idle_r1: assert property (@(posedge clk) rst |=> (!out_vld && !state.run));

    // R2 / R8: a captured strobe always starts at branch 0
    p_start_r8: assert property (@(posedge clk) disable iff (rst)
        sym_vld |=> (state.run && state.phase == '0));

    // R2: the run ends after the last branch
    p_len_r2: assert property (@(posedge clk) disable iff (rst)
        (state.run && state.phase == LAST && !sym_vld) |=> !state.run);

    // R7: a burst start without a strobe stops the sequence
    p_burst_r7: assert property (@(posedge clk) disable iff (rst)
        (burst_start && !sym_vld) |=> !state.run);

endmodule

// File: rtl/rrc_coef_bank.sv
module rrc_coef_bank
    import rrc_pkg::*;
#(
    parameter int COEF_W    = 12,
    parameter int COEF_FRAC = 10
) (
    input  phase_t                   phase,
    output logic signed [COEF_W-1:0] branch [SPAN]
);

    logic signed [COEF_W-1:0] tbl [SPAN][OSR];

    for (genvar j = 0; j < SPAN; j++) begin : g_tap
        for (genvar p = 0; p < OSR; p++) begin : g_ph
            localparam int CV = rrc_coef(j * OSR + p, COEF_FRAC);
            assign tbl[j][p] = COEF_W'(CV);
        end
        assign branch[j] = tbl[j][phase];
    end

endmodule

// File: rtl/rrc_fir_chan.sv
module rrc_fir_chan #(
    parameter int IN_W      = 10,
    parameter int OUT_W     = 10,
    parameter int COEF_W    = 12,
    parameter int COEF_FRAC = 10,
    parameter int TAPS      = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     shift,
    input  logic                     calc,
    input  logic signed [IN_W-1:0]   din,
    input  logic signed [COEF_W-1:0] coef [TAPS],
    output logic signed [OUT_W-1:0]  dout
);

    localparam int ACC_W = IN_W + COEF_W + $clog2(TAPS) + 1;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(2 ** (COEF_FRAC - 1));
    localparam logic signed [ACC_W-1:0] OMAX = ACC_W'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [ACC_W-1:0] OMIN = ACC_W'(-(2 ** (OUT_W - 1)));

    logic signed [IN_W-1:0]  hist [TAPS];
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] scaled;
    logic signed [OUT_W-1:0] clipped;
    logic                    tail_nz;

    always_comb begin
        acc = '0;
        for (int j = 0; j < TAPS; j++) begin
            acc = acc + ACC_W'(hist[j]) * ACC_W'(coef[j]);
        end
        scaled = (acc + HALF) >>> COEF_FRAC;
        if (scaled > OMAX)
            clipped = OMAX[OUT_W-1:0];
        else if (scaled < OMIN)
            clipped = OMIN[OUT_W-1:0];
        else
            clipped = scaled[OUT_W-1:0];
    end

    always_comb begin
        tail_nz = 1'b0;
        for (int j = 1; j < TAPS; j++) begin
            tail_nz = tail_nz | (|hist[j]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < TAPS; j++) hist[j] <= '0;
            dout <= '0;
        end else begin
            if (clear || shift) begin
                hist[0] <= shift ? din : '0;
                for (int j = 1; j < TAPS; j++) begin
                    hist[j] <= clear ? '0 : hist[j-1];
                end
            end
            if (calc) dout <= clipped;
        end
    end

    // R7: a clear alone empties the whole history
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clear && !shift) |=> (!tail_nz && hist[0] == '0));

    // R7: clear with a strobe keeps only the new symbol
    p_clear_load_r7: assert property (@(posedge clk) disable iff (rst)
        (clear && shift) |=> (!tail_nz && hist[0] == $past(din)));

    // R3: a strobe moves every entry one place older
    p_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (shift && !clear) |=> (hist[0] == $past(din) && hist[TAPS-1] == $past(hist[TAPS-2])));

    // R6: results above the range clip to the top
    p_sat_hi_r6: assert property (@(posedge clk) disable iff (rst)
        (calc && scaled > OMAX) |=> dout == OMAX[OUT_W-1:0]);

    // R6: results below the range clip to the bottom
    p_sat_lo_r6: assert property (@(posedge clk) disable iff (rst)
        (calc && scaled < OMIN) |=> dout == OMIN[OUT_W-1:0]);

    // R9: no computation, no change
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !calc |=> $stable(dout));

endmodule

// File: rtl/rrc_interp.sv
module rrc_interp
    import rrc_pkg::*;
#(
    parameter int IN_W      = 10,
    parameter int OUT_W     = 10,
    parameter int COEF_W    = 12,
    parameter int COEF_FRAC = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    burst_start,
    input  logic                    sym_vld,
    input  logic signed [IN_W-1:0]  sym_i,
    input  logic signed [IN_W-1:0]  sym_q,
    output logic                    smp_vld,
    output logic signed [OUT_W-1:0] smp_i,
    output logic signed [OUT_W-1:0] smp_q
);

    seq_state_t               st;
    logic signed [COEF_W-1:0] branch [SPAN];
    logic signed [IN_W-1:0]   ch_in  [NUM_CH];
    logic signed [OUT_W-1:0]  ch_out [NUM_CH];

    assign ch_in[CH_I] = sym_i;
    assign ch_in[CH_Q] = sym_q;

    rrc_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .burst_start (burst_start),
        .sym_vld     (sym_vld),
        .state       (st),
        .out_vld     (smp_vld)
    );

    rrc_coef_bank #(
        .COEF_W    (COEF_W),
        .COEF_FRAC (COEF_FRAC)
    ) u_bank (
        .phase  (st.phase),
        .branch (branch)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        rrc_fir_chan #(
            .IN_W      (IN_W),
            .OUT_W     (OUT_W),
            .COEF_W    (COEF_W),
            .COEF_FRAC (COEF_FRAC),
            .TAPS      (SPAN)
        ) u_chan (
            .clk   (clk),
            .rst   (rst),
            .clear (burst_start),
            .shift (sym_vld),
            .calc  (st.run),
            .din   (ch_in[c]),
            .coef  (branch),
            .dout  (ch_out[c])
        );
    end

    assign smp_i = ch_out[CH_I];
    assign smp_q = ch_out[CH_Q];

    // R2: a sample strobe always follows a running sequencer cycle
    p_vld_r2: assert property (@(posedge clk) disable iff (rst)
        smp_vld |-> $past(st.run));

endmodule

// File: tb/rrc_interp_bench.sv
module rrc_interp_bench;

    localparam int OSR  = 8;
    localparam int SPAN = 8;
    localparam int NT   = OSR * SPAN;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic burst_start = 1'b0;
    logic sym_vld = 1'b0;
    logic signed [9:0] sym_i = '0;
    logic signed [9:0] sym_q = '0;
    logic smp_vld;
    logic signed [9:0] smp_i;
    logic signed [9:0] smp_q;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    int coef [NT];
    int hi [SPAN];
    int hq [SPAN];
    int carry_v = 0, carry_i = 0, carry_q = 0;
    int last_i = 0, last_q = 0;
    int pts [5] = '{-256, -181, 0, 181, 256};

    always #5 clk = ~clk;

    rrc_interp u_rrc_interp (
        .clk(clk), .rst(rst), .burst_start(burst_start), .sym_vld(sym_vld),
        .sym_i(sym_i), .sym_q(sym_q), .smp_vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q)
    );

    function automatic real pulse(real t);
        real b = 0.5;
        real pi = 3.14159265358979323846;
        real d;
        if (t == 0.0) return 1.0 - b + 4.0 * b / pi;
        if (4.0 * b * t == 1.0 || 4.0 * b * t == -1.0)
            return (b / $sqrt(2.0)) * ((1.0 + 2.0 / pi) * $sin(pi / (4.0 * b))
                                     + (1.0 - 2.0 / pi) * $cos(pi / (4.0 * b)));
        d = pi * t * (1.0 - (4.0 * b * t) * (4.0 * b * t));
        return ($sin(pi * t * (1.0 - b)) + 4.0 * b * t * $cos(pi * t * (1.0 + b))) / d;
    endfunction

    function automatic int model(input int h [SPAN], input int p);
        longint acc = 0;
        for (int j = 0; j < SPAN; j++) acc += longint'(h[j]) * longint'(coef[j * OSR + p]);
        acc = (acc + 512) >>> 10;
        if (acc > 511) acc = 511;
        if (acc < -512) acc = -512;
        return int'(acc);
    endfunction

    task automatic check(input string tag, input int ev, input int ei, input int eq);
        n_chk++;
        if (int'(smp_vld) != ev || int'(smp_i) != ei || int'(smp_q) != eq) begin
            n_err++;
            $display("FAIL %s: vld=%0d i=%0d q=%0d expected vld=%0d i=%0d q=%0d",
                     tag, smp_vld, smp_i, smp_q, ev, ei, eq);
        end
    endtask

    // drive one edge of stimulus at a falling edge, then check gap falling edges
    task automatic step(input string tag, input bit strobe, input bit clr,
                        input int vi, input int vq, input int gap);
        int ei [OSR];
        int eq [OSR];
        burst_start = clr;
        sym_vld = strobe;
        sym_i = 10'(vi);
        sym_q = 10'(vq);
        if (clr) for (int j = 0; j < SPAN; j++) begin hi[j] = 0; hq[j] = 0; end
        if (strobe) begin
            for (int j = SPAN - 1; j > 0; j--) begin hi[j] = hi[j-1]; hq[j] = hq[j-1]; end
            hi[0] = vi;
            hq[0] = vq;
        end
        for (int p = 0; p < OSR; p++) begin ei[p] = model(hi, p); eq[p] = model(hq, p); end
        for (int k = 1; k <= gap; k++) begin
            @(negedge clk);
            sym_vld = 1'b0;
            burst_start = 1'b0;
            if (k == 1) begin
                if (carry_v != 0) begin last_i = carry_i; last_q = carry_q; end
                check(tag, carry_v, last_i, last_q);
            end else if (strobe && k - 2 < OSR) begin
                last_i = ei[k-2];
                last_q = eq[k-2];
                check(tag, 1, last_i, last_q);
            end else begin
                check(tag, 0, last_i, last_q);
            end
        end
        if (strobe && gap - 1 < OSR) begin
            carry_v = 1;
            carry_i = ei[gap-1];
            carry_q = eq[gap-1];
        end else begin
            carry_v = 0;
        end
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog R2: actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7731));
        for (int k = 0; k < NT; k++) begin
            real v;
            v = pulse(real'(k - NT / 2) / real'(OSR)) * 1024.0;
            coef[k] = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
        end
        for (int j = 0; j < SPAN; j++) begin hi[j] = 0; hq[j] = 0; end

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset", 0, 0, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 0, 0, 0);
        // R1: history is empty, so a lone symbol gives its own pulse only
        step("R1 empty history", 1, 0, 256, 0, 10);

        // R3: impulse walked through every branch
        step("R3 impulse", 1, 1, 256, 0, 10);
        for (int s = 0; s < SPAN; s++) step("R3 impulse tail", 1, 0, 0, 0, 9);

        // R4: independent channels
        step("R4 q only", 1, 1, 0, -200, 9);
        step("R4 mixed", 1, 0, 137, -77, 9);
        for (int s = 0; s < 4; s++) step("R4 mixed tail", 1, 0, 0, 0, 9);

        // R5: exact half cases and tiny values
        step("R5 half", 1, 1, -512, -1, 9);
        step("R5 small", 1, 0, 1, -3, 9);
        for (int s = 0; s < 3; s++) step("R5 tail", 1, 0, 0, 0, 9);

        // R6: long runs of full-scale values saturate both ways
        for (int s = 0; s < SPAN; s++) step("R6 full scale", 1, s == 0, 511, -512, 9);
        for (int s = 0; s < 4; s++) step("R6 alternating", 1, 0, (s % 2) ? -512 : 511, (s % 2) ? 511 : -512, 9);

        // R7: clear alone mid-sequence, then a zero symbol must give silence
        step("R7 load", 1, 0, 256, 181, 4);
        step("R7 clear", 0, 1, 0, 0, 3);
        step("R7 after clear", 1, 0, 0, 0, 10);
        step("R7 clear with strobe", 1, 1, -181, 256, 9);

        // R8: strobes arriving before the sequence completes
        step("R8 restart", 1, 0, 256, -256, 3);
        step("R8 restart", 1, 0, -181, 181, 1);
        step("R8 restart", 1, 0, 181, 0, 5);
        step("R8 restart end", 1, 0, 0, -181, 9);

        // R9: outputs hold over a long idle gap
        step("R9 hold", 1, 0, 256, 256, 24);

        // R2: mixed random traffic with varying gaps and occasional clears
        for (int n = 0; n < 400; n++) begin
            int gap;
            bit clr;
            gap = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 12)) : 9;
            clr = ($urandom_range(0, 39) == 0);
            step("R2 random", 1, clr, pts[$urandom_range(0, 4)], pts[$urandom_range(0, 4)], gap);
        end
        step("R2 drain", 0, 0, 0, 0, 12);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule